// File: doc/BRIEF.md
# Continuous Configuration-Memory CRC Monitor

This block watches a configuration memory for silent corruption once configuration has finished. It reads every word of the memory through a simple synchronous read port, over and over, and computes a 32-bit CRC over each complete pass. At the end of a pass it XORs the pass CRC with a reference value. That reference was latched into a storage register when configuration finished. The result is loaded into a signature register.

A signature of zero means the memory still matches the reference. Any non-zero signature raises `crc_error`. The block takes no corrective action. External logic reads `crc_error` and decides whether to reconfigure, by pulling `cfg_rst_n` low, or to ignore the error. Scanning runs without end until `cfg_rst_n` is driven low.

A control state machine sequences the work through four states: idle, scan, compare and restart. Word width and memory depth are parameters.

Top module: `cfg_crc_monitor`

## Requirements
- R1: While `cfg_rst_n` is low, `crc_error` is 0, `signature` is 0 and `rd_en` is 0. After `cfg_rst_n` is released, no read is issued until `cfg_done` is seen.
- R2: A `cfg_done` pulse while idle latches `ref_crc` into the storage register and starts scanning. Later changes on `ref_crc` have no effect until the next reset.
- R3: During a pass, `rd_en` is high and `rd_addr` steps 0, 1, …, DEPTH-1, one address per cycle. Read data is taken one cycle after its address.
- R4: Passes repeat without end. Consecutive starts at address 0 are exactly DEPTH+2 cycles apart.
- R5: The pass CRC uses the reflected IEEE 802 polynomial 0xEDB88320 with initial value 0xFFFFFFFF. Each word is fed least significant bit first, and the result is inverted at the end. With 8-bit words, the bytes "123456789" give 0xCBF43926.
- R6: At the end of each pass, `signature` is loaded with the pass CRC XOR the stored reference. It is all zeros when they match.
- R7: `crc_error` equals the OR of all signature bits. It changes only at the end of a pass, so it clears when a later pass matches.
- R8: A single bit flipped in memory during a pass is not reported by that pass if the word was already read. The next complete pass raises `crc_error`. Once the bit is restored, the pass after that clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cfg_rst_n | input | 1 | Active-low configuration reset, asynchronous |
| cfg_done | input | 1 | Configuration finished; latches reference and starts scanning |
| ref_crc | input | 32 | Pre-computed reference CRC |
| rd_en | output | 1 | Memory read enable |
| rd_addr | output | ADDR_W | Memory read address |
| rd_data | input | DATA_W | Memory read data, one cycle after address |
| signature | output | 32 | Last pass signature (zero = match) |
| crc_error | output | 1 | High when the signature is non-zero |

## Verification
A wrong address sequence or a CRC engine fault shows up as a wrong `signature` no later than the end of the pass in which it occurred. That is at most DEPTH+2 cycles. A storage register that drifts or reloads corrupts every following signature. A compare step placed in the wrong cycle drops or double-counts a word, so even a clean memory gives a non-zero signature.

The bench flips every memory bit in turn. It expects an exact signature after the next full pass and a clean result after the bit is restored. This makes each of these faults visible within one or two passes.

// File: rtl/crcmon_pkg.sv
package crcmon_pkg;
   localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;
   localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_SCAN    = 2'd1,
      ST_COMPARE = 2'd2,
      ST_RESTART = 2'd3
   } mon_state_t;
endpackage

// File: rtl/crcmon_seq.sv
module crcmon_seq
   import crcmon_pkg::*;
#(
   parameter int DEPTH  = 64,
   parameter int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output mon_state_t        state,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              rd_vld
);
   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

   mon_state_t        st_q;
   logic [ADDR_W-1:0] addr_q;
   logic              vld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         addr_q <= '0;
         vld_q  <= 1'b0;
      end else begin
         vld_q <= (st_q == ST_SCAN);
         case (st_q)
            ST_IDLE: begin
               if (start) begin
                  st_q   <= ST_SCAN;
                  addr_q <= '0;
               end
            end
            ST_SCAN: begin
               if (addr_q == LAST) st_q <= ST_COMPARE;
               else                addr_q <= addr_q + 1'b1;
            end
            ST_COMPARE: st_q <= ST_RESTART;
            default: begin
               st_q   <= ST_SCAN;
               addr_q <= '0;
            end
         endcase
      end
   end

   assign state   = st_q;
   assign rd_en   = (st_q == ST_SCAN);
   assign rd_addr = addr_q;
   assign rd_vld  = vld_q;

   p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr != '0) |-> ($past(rd_en) && rd_addr == $past(rd_addr) + 1'b1));
   p_compare_to_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_COMPARE) |=> (st_q == ST_RESTART));
   p_restart_to_scan_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RESTART) |=> (rd_en && rd_addr == '0));
endmodule

// File: rtl/crcmon_engine.sv
module crcmon_engine
   import crcmon_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              en,
   input  logic [DATA_W-1:0] data,
   output logic [31:0]       crc_final
);
   logic [31:0] crc_q;
   logic [31:0] crc_nx;

   function automatic logic [31:0] fold_word(input logic [31:0] c, input logic [DATA_W-1:0] d);
      logic [31:0] r;
      logic        fb;
      r = c;
      for (int i = 0; i < DATA_W; i++) begin
         fb = r[0] ^ d[i];
         r  = {1'b0, r[31:1]};
         if (fb) r = r ^ CRC_POLY;
      end
      return r;
   endfunction

   assign crc_nx    = fold_word(crc_q, data);
   assign crc_final = ~crc_nx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   crc_q <= CRC_INIT;
      else if (clr) crc_q <= CRC_INIT;
      else if (en)  crc_q <= crc_nx;
   end

   p_clear_init_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (crc_q == CRC_INIT));
endmodule

// File: rtl/cfg_crc_monitor.sv
module cfg_crc_monitor
   import crcmon_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 64,
   parameter int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              cfg_rst_n,
   input  logic              cfg_done,
   input  logic [31:0]       ref_crc,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] rd_data,
   output logic [31:0]       signature,
   output logic              crc_error
);
   generate
      if (DATA_W < 1 || DATA_W > 64) begin : g_bad_width
         $error("cfg_crc_monitor: DATA_W must be 1..64");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("cfg_crc_monitor: DEPTH must be at least 2");
      end
      if ((1 << ADDR_W) < DEPTH) begin : g_bad_addr
         $error("cfg_crc_monitor: ADDR_W too narrow for DEPTH");
      end
   endgenerate

   mon_state_t  state;
   logic        rd_vld;
   logic        crc_clr;
   logic [31:0] crc_final;
   logic [31:0] store_q;
   logic [31:0] sig_q;
   logic        err_q;
   logic [31:0] sig_nx;
   logic        pass_end;
   logic        load_ref;

   crcmon_seq #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_seq (
      .clk     (clk),
      .rst_n   (cfg_rst_n),
      .start   (cfg_done),
      .state   (state),
      .rd_en   (rd_en),
      .rd_addr (rd_addr),
      .rd_vld  (rd_vld)
   );

   assign crc_clr = (state == ST_IDLE) || (state == ST_RESTART);

   crcmon_engine #(.DATA_W(DATA_W)) u_crc (
      .clk       (clk),
      .rst_n     (cfg_rst_n),
      .clr       (crc_clr),
      .en        (rd_vld),
      .data      (rd_data),
      .crc_final (crc_final)
   );

   assign load_ref = (state == ST_IDLE) && cfg_done;
   assign pass_end = (state == ST_COMPARE);
   assign sig_nx   = crc_final ^ store_q;

   always_ff @(posedge clk or negedge cfg_rst_n) begin
      if (!cfg_rst_n) begin
         store_q <= '0;
         sig_q   <= '0;
         err_q   <= 1'b0;
      end else begin
         if (load_ref) store_q <= ref_crc;
         if (pass_end) begin
            sig_q <= sig_nx;
            err_q <= |sig_nx;
         end
      end
   end

   assign signature = sig_q;
   assign crc_error = err_q;

   p_reset_quiet_r1: assert property (@(posedge clk)
      !cfg_rst_n |=> (!crc_error && !rd_en && signature == '0));
   p_store_hold_r2: assert property (@(posedge clk) disable iff (!cfg_rst_n)
      (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(store_q));
   p_err_only_at_end_r7: assert property (@(posedge clk) disable iff (!cfg_rst_n)
      !$past(pass_end) |-> $stable(crc_error));
   p_err_tracks_sig_r7: assert property (@(posedge clk) disable iff (!cfg_rst_n)
      crc_error == (signature != '0));
endmodule

// File: tb/sim_cfg_crc_monitor.sv
`timescale 1ns/1ps
module sim_cfg_crc_monitor;
   localparam int DW = 8;
   localparam int D  = 9;
   localparam int AW = $clog2(D);
   localparam logic [31:0] GOOD_REF = 32'hCBF4_3926;

   logic          clk = 1'b0;
   logic          cfg_rst_n = 1'b0;
   logic          cfg_done = 1'b0;
   logic [31:0]   ref_crc = '0;
   logic          rd_en;
   logic [AW-1:0] rd_addr;
   logic [DW-1:0] rd_data = '0;
   logic [31:0]   signature;
   logic          crc_error;
   logic [DW-1:0] mem [D];
   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always #2 clk = ~clk;

   cfg_crc_monitor #(.DATA_W(DW), .DEPTH(D)) u0 (
      .clk(clk), .cfg_rst_n(cfg_rst_n), .cfg_done(cfg_done), .ref_crc(ref_crc),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .signature(signature), .crc_error(crc_error));

   always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         errors = errors + 1;
         $display("FAIL watchdog: run hung, actual cycle %0d expected < 150000", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   function automatic logic [31:0] ref_crc_of_mem();
      logic [31:0] c = 32'hFFFF_FFFF;
      for (int w = 0; w < D; w++)
         for (int b = 0; b < DW; b++)
            c = (c >> 1) ^ ({32{c[0] ^ mem[w][b]}} & 32'hEDB8_8320);
      return ~c;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wait_start();
      @(negedge clk);
      while (!(rd_en && rd_addr == '0)) @(negedge clk);
   endtask

   task automatic run_pass();
      wait_start();
      repeat (D + 1) @(negedge clk);
   endtask

   task automatic load_mem();
      for (int i = 0; i < D; i++) mem[i] = DW'(8'h31 + i);
   endtask

   task automatic do_reset();
      cfg_rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 err in reset", {31'd0, crc_error}, 32'd0);
      chk("R1 rd_en in reset", {31'd0, rd_en}, 32'd0);
      chk("R1 sig in reset", signature, 32'd0);
      cfg_rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R1 no read before done", {31'd0, rd_en}, 32'd0);
   endtask

   task automatic start(input logic [31:0] r);
      ref_crc = r;
      cfg_done = 1'b1;
      @(negedge clk);
      cfg_done = 1'b0;
   endtask

   initial begin
      int t0;
      int t1;
      int bad;
      load_mem();
      do_reset();
      start(GOOD_REF);
      ref_crc = 32'h1234_5678;
      chk("R5 model check value", ref_crc_of_mem(), GOOD_REF);

      // R3: address order over one pass
      wait_start();
      bad = 0;
      for (int a = 1; a < D; a++) begin
         @(negedge clk);
         if (!(rd_en && rd_addr == AW'(a))) bad++;
      end
      chk("R3 address sequence", bad, 0);

      // R4: period between starts
      wait_start(); t0 = cyc;
      wait_start(); t1 = cyc;
      chk("R4 pass period", t1 - t0, D + 2);

      // R5, R6, R2: clean pass with ref input changed after start
      run_pass();
      chk("R5 R6 clean signature", signature, 32'd0);
      chk("R2 ref change ignored", {31'd0, crc_error}, 32'd0);

      // R8: flip in a word already read mid-pass
      wait_start();
      repeat (4) @(negedge clk);
      mem[1][3] = ~mem[1][3];
      repeat (D + 1 - 4) @(negedge clk);
      chk("R8 current pass still clean", {31'd0, crc_error}, 32'd0);
      run_pass();
      chk("R8 next pass flags", {31'd0, crc_error}, 32'd1);
      chk("R6 signature value", signature, ref_crc_of_mem() ^ GOOD_REF);
      // R7: stable inside the following pass
      wait_start();
      mem[1][3] = ~mem[1][3];
      bad = 0;
      for (int k = 0; k < D; k++) begin
         if (crc_error !== 1'b1) bad++;
         @(negedge clk);
      end
      chk("R7 held during pass", bad, 0);
      @(negedge clk);
      chk("R7 clears on matching pass", {31'd0, crc_error}, 32'd0);

      // R8 sweep: every single bit
      for (int w = 0; w < D; w++) begin
         for (int b = 0; b < DW; b++) begin
            mem[w][b] = ~mem[w][b];
            run_pass();
            chk("R8 sweep flag", {31'd0, crc_error}, 32'd1);
            chk("R6 sweep sig", signature, ref_crc_of_mem() ^ GOOD_REF);
            mem[w][b] = ~mem[w][b];
            run_pass();
            chk("R8 sweep clear", {31'd0, crc_error}, 32'd0);
         end
      end

      // R1: reset mid-run drops error and stops reads
      mem[0][0] = ~mem[0][0];
      run_pass();
      chk("R8 before reset", {31'd0, crc_error}, 32'd1);
      do_reset();
      mem[0][0] = ~mem[0][0];

      // R2, R6: wrong reference latched
      start(32'hDEAD_BEEF);
      run_pass();
      chk("R2 R6 wrong ref sig", signature, GOOD_REF ^ 32'hDEAD_BEEF);
      chk("R7 wrong ref err", {31'd0, crc_error}, 32'd1);
      run_pass();
      chk("R4 endless repeat", {31'd0, crc_error}, 32'd1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule